// File: doc/BRIEF.md
# Two-Level Maskable Interrupt Controller

This block gathers interrupt events from peripheral sources and presents one interrupt request, with a core line index and a peripheral vector, to a processor core. Each source has a sticky flag latch and an enable bit. External pin sources also have a polarity bit that selects the active edge. Sources are grouped by core line. A fixed-priority arbiter inside each group picks the lowest-numbered pending source and reports its local index.

A source that becomes pending posts a request on its core line, and that request sets a core flag latch. The core flag is gated by a per-line core mask and then by a global interrupt enable. When the core acknowledges, the controller clears the core flag of the line being serviced and drops the global enable. Software turns the global enable back on with an explicit set strobe. Flags are cleared through write-one-to-clear ports, and every register can be read back directly on an output port.

Top module: `irqc_top`

## Requirements
- R1: A valid event on source s sets src_flag[s] at the next clock edge, whatever src_en[s] holds. The flag then stays set until it is cleared.
- R2: Source s is a pin source when (s mod SRCS_PER_LINE) < EXT_PER_LINE, which with the defaults means bits 0, 3 and 6. For a pin source, src_pol=1 makes a rising level change valid and src_pol=0 makes a falling change valid. The pin level is taken as 0 at reset. Any other source counts a high src_in in a cycle as an event. Its src_pol bit always reads 0 and has no effect.
- R3: Source s is pending when both its flag and its enable are 1. It belongs to core line s / SRCS_PER_LINE. When a source goes from not pending to pending, the core flag of its line is set one edge later. An event therefore raises irq two edges after it is sampled, provided the mask and the global enable allow it.
- R4: irq_pvec is the lowest local index (s mod SRCS_PER_LINE) among the pending sources of the serviced line.
- R5: irq is 1 exactly when gie is 1 and at least one line has both core_flag and core_mask set. irq_line is the lowest such line.
- R6: A 1 in src_flag_clr or core_flag_clr clears that flag at the next edge. A 0 bit leaves its flag unchanged.
- R7: An irq_ack while irq is 1 clears core_flag[irq_line] and gie at the next edge and leaves the other core flags unchanged. gie returns to 1 only through gie_set.
- R8: When an event and a clear of the same source flag fall in the same cycle, the event wins and the flag stays set.
- R9: After reset all flags, enables, polarity bits, masks and gie are 0, and irq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NUM_LINES*SRCS_PER_LINE | Pin levels for pin sources, event strobes for the others |
| src_en_wr | input | NUM_LINES*SRCS_PER_LINE == 1 ? 1 : 1 | Write strobe for the enable register |
| src_en_wdata | input | NUM_LINES*SRCS_PER_LINE | New enable bits |
| src_pol_wr | input | 1 | Write strobe for the polarity register |
| src_pol_wdata | input | NUM_LINES*SRCS_PER_LINE | New polarity bits (only pin bits are kept) |
| src_flag_clr | input | NUM_LINES*SRCS_PER_LINE | Write-one-to-clear for the source flags |
| core_mask_wr | input | 1 | Write strobe for the core mask |
| core_mask_wdata | input | NUM_LINES | New core mask bits |
| core_flag_clr | input | NUM_LINES | Write-one-to-clear for the core flags |
| gie_set | input | 1 | Sets the global enable |
| gie_clr | input | 1 | Clears the global enable (takes precedence over set) |
| irq_ack | input | 1 | Core acknowledge |
| src_flag | output | NUM_LINES*SRCS_PER_LINE | Source flags |
| src_en | output | NUM_LINES*SRCS_PER_LINE | Source enables |
| src_pol | output | NUM_LINES*SRCS_PER_LINE | Polarity bits |
| core_flag | output | NUM_LINES | Core flags |
| core_mask | output | NUM_LINES | Core mask |
| gie | output | 1 | Global interrupt enable |
| irq | output | 1 | Interrupt request to the core |
| irq_line | output | clog2(NUM_LINES) | Index of the serviced core line |
| irq_pvec | output | clog2(SRCS_PER_LINE) | Local index of the winning source on that line |

## Verification
A source flag changes one edge after its event, clear, or event-plus-clear is sampled. irq, irq_line and irq_pvec settle one edge after that, because the newly pending source has to pass through the core flag register first. An enable, mask or global-enable write acts on the edge after the write, and the request decodes combinationally from those registers. An acknowledge clears the core flag and gie on the edge where it is sampled. The bench drives every input just after a falling edge and samples just before the next rising edge, stepping exactly the number of edges given above for each result. It sweeps every source with its enable both off and on, every subset of one line's sources for the arbiter, and both polarity settings on a pin.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // Index width for a count of n items, never narrower than one bit.
  function automatic int idx_w(input int n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/irqc_src_stage.sv
module irqc_src_stage
  import irqc_pkg::*;
#(
  parameter int NUM_LINES     = 3,
  parameter int SRCS_PER_LINE = 3,
  parameter int EXT_PER_LINE  = 1
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [NUM_LINES*SRCS_PER_LINE-1:0]     src_in,
  input  logic                                   en_wr,
  input  logic [NUM_LINES*SRCS_PER_LINE-1:0]     en_wdata,
  input  logic                                   pol_wr,
  input  logic [NUM_LINES*SRCS_PER_LINE-1:0]     pol_wdata,
  input  logic [NUM_LINES*SRCS_PER_LINE-1:0]     flag_clr,
  output logic [NUM_LINES*SRCS_PER_LINE-1:0]     flag_q,
  output logic [NUM_LINES*SRCS_PER_LINE-1:0]     en_q,
  output logic [NUM_LINES*SRCS_PER_LINE-1:0]     pol_q,
  output logic [NUM_LINES*SRCS_PER_LINE-1:0]     pend
);
  localparam int NSRC = NUM_LINES * SRCS_PER_LINE;

  logic [NSRC-1:0] pin_mask;
  logic [NSRC-1:0] evt;
  logic [NSRC-1:0] flag_d;
  logic [NSRC-1:0] pol_d;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    localparam bit IS_PIN = (s % SRCS_PER_LINE) < EXT_PER_LINE;
    if (IS_PIN) begin : g_pin
      logic lvl_q;
      assign pin_mask[s] = 1'b1;
      assign evt[s] = pol_q[s] ? (src_in[s] & ~lvl_q) : (~src_in[s] & lvl_q);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= src_in[s];
      end
    end else begin : g_int
      assign pin_mask[s] = 1'b0;
      assign evt[s]      = src_in[s];
    end

    // R1: a set flag survives any cycle without a clear
    p_flag_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[s] && !flag_clr[s]) |=> flag_q[s]);
    // R8: an event always leaves the flag set, even against a clear
    p_evt_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      evt[s] |=> flag_q[s]);
  end

  always_comb begin
    flag_d = (flag_q & ~flag_clr) | evt;
    pol_d  = pol_wdata & pin_mask;
    pend   = flag_q & en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      en_q   <= '0;
      pol_q  <= '0;
    end else begin
      flag_q <= flag_d;
      if (en_wr)  en_q  <= en_wdata;
      if (pol_wr) pol_q <= pol_d;
    end
  end
endmodule

// File: rtl/irqc_line_arb.sv
module irqc_line_arb
  import irqc_pkg::*;
#(
  parameter int NUM_LINES     = 3,
  parameter int SRCS_PER_LINE = 3
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic [NUM_LINES*SRCS_PER_LINE-1:0]            pend,
  output logic [NUM_LINES-1:0]                          line_post,
  output logic [NUM_LINES*idx_w(SRCS_PER_LINE)-1:0]     line_vec
);
  localparam int NSRC = NUM_LINES * SRCS_PER_LINE;
  localparam int PW   = idx_w(SRCS_PER_LINE);

  logic [NSRC-1:0] pend_q;
  logic [NSRC-1:0] fresh;

  assign fresh = pend & ~pend_q;

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    logic [SRCS_PER_LINE-1:0] grp;
    logic [PW-1:0]            vec;
    assign grp = pend[l*SRCS_PER_LINE +: SRCS_PER_LINE];

    always_comb begin
      vec = '0;
      for (int k = SRCS_PER_LINE - 1; k >= 0; k--) begin
        if (grp[k]) vec = PW'(k);
      end
    end

    assign line_vec[l*PW +: PW] = vec;
    assign line_post[l] = |fresh[l*SRCS_PER_LINE +: SRCS_PER_LINE];

    // R4: the published index points at a pending source
    p_vec_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (|grp) |-> grp[vec]);
    // R4: no pending source sits below the published index
    p_vec_lowest_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (grp & ~({SRCS_PER_LINE{1'b1}} << vec)) == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend;
  end
endmodule

// File: rtl/irqc_core_stage.sv
module irqc_core_stage
  import irqc_pkg::*;
#(
  parameter int NUM_LINES     = 3,
  parameter int SRCS_PER_LINE = 3
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic [NUM_LINES-1:0]                          line_post,
  input  logic [NUM_LINES*idx_w(SRCS_PER_LINE)-1:0]     line_vec,
  input  logic                                          mask_wr,
  input  logic [NUM_LINES-1:0]                          mask_wdata,
  input  logic [NUM_LINES-1:0]                          flag_clr,
  input  logic                                          gie_set,
  input  logic                                          gie_clr,
  input  logic                                          ack,
  output logic [NUM_LINES-1:0]                          flag_q,
  output logic [NUM_LINES-1:0]                          mask_q,
  output logic                                          gie_q,
  output logic                                          irq,
  output logic [idx_w(NUM_LINES)-1:0]                   irq_line,
  output logic [idx_w(SRCS_PER_LINE)-1:0]               irq_pvec
);
  localparam int LW = idx_w(NUM_LINES);
  localparam int PW = idx_w(SRCS_PER_LINE);

  logic [NUM_LINES-1:0] active;
  logic [NUM_LINES-1:0] ack_clr;
  logic [NUM_LINES-1:0] flag_d;
  logic [LW-1:0]        sel;
  logic                 ack_take;
  logic                 gie_d;

  always_comb begin
    active = flag_q & mask_q;
    sel    = '0;
    for (int l = NUM_LINES - 1; l >= 0; l--) begin
      if (active[l]) sel = LW'(l);
    end
    irq      = gie_q & (|active);
    irq_line = sel;
    irq_pvec = line_vec[int'(sel)*PW +: PW];
    ack_take = ack & irq;
    ack_clr  = '0;
    if (ack_take) ack_clr[sel] = 1'b1;
    flag_d   = (flag_q & ~(flag_clr | ack_clr)) | line_post;
    if (ack_take || gie_clr) gie_d = 1'b0;
    else if (gie_set)        gie_d = 1'b1;
    else                     gie_d = gie_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      mask_q <= '0;
      gie_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      gie_q  <= gie_d;
      if (mask_wr) mask_q <= mask_wdata;
    end
  end

  // R3: a posted line request lands in the core flag latch
  p_post_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|line_post) |=> ((flag_q & $past(line_post)) == $past(line_post)));
  // R7: taking an acknowledge drops the global enable
  p_ack_drops_gie_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq) |=> !gie_q);
  // R7: the global enable comes back only through the set strobe
  p_gie_only_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!gie_q && !gie_set) |=> !gie_q);
  // R7: the serviced line's core flag is cleared unless reposted
  p_ack_clears_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq && !line_post[irq_line]) |=> !flag_q[$past(irq_line)]);
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int NUM_LINES     = 3,
  parameter int SRCS_PER_LINE = 3,
  parameter int EXT_PER_LINE  = 1
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [NUM_LINES*SRCS_PER_LINE-1:0]     src_in,
  input  logic                                   src_en_wr,
  input  logic [NUM_LINES*SRCS_PER_LINE-1:0]     src_en_wdata,
  input  logic                                   src_pol_wr,
  input  logic [NUM_LINES*SRCS_PER_LINE-1:0]     src_pol_wdata,
  input  logic [NUM_LINES*SRCS_PER_LINE-1:0]     src_flag_clr,
  input  logic                                   core_mask_wr,
  input  logic [NUM_LINES-1:0]                   core_mask_wdata,
  input  logic [NUM_LINES-1:0]                   core_flag_clr,
  input  logic                                   gie_set,
  input  logic                                   gie_clr,
  input  logic                                   irq_ack,
  output logic [NUM_LINES*SRCS_PER_LINE-1:0]     src_flag,
  output logic [NUM_LINES*SRCS_PER_LINE-1:0]     src_en,
  output logic [NUM_LINES*SRCS_PER_LINE-1:0]     src_pol,
  output logic [NUM_LINES-1:0]                   core_flag,
  output logic [NUM_LINES-1:0]                   core_mask,
  output logic                                   gie,
  output logic                                   irq,
  output logic [idx_w(NUM_LINES)-1:0]            irq_line,
  output logic [idx_w(SRCS_PER_LINE)-1:0]        irq_pvec
);
  localparam int NSRC = NUM_LINES * SRCS_PER_LINE;
  localparam int PW   = idx_w(SRCS_PER_LINE);

  logic [NSRC-1:0]         pend;
  logic [NUM_LINES-1:0]    line_post;
  logic [NUM_LINES*PW-1:0] line_vec;

  irqc_src_stage #(
    .NUM_LINES(NUM_LINES), .SRCS_PER_LINE(SRCS_PER_LINE), .EXT_PER_LINE(EXT_PER_LINE)
  ) u_src (
    .clk(clk), .rst_n(rst_n), .src_in(src_in),
    .en_wr(src_en_wr), .en_wdata(src_en_wdata),
    .pol_wr(src_pol_wr), .pol_wdata(src_pol_wdata),
    .flag_clr(src_flag_clr),
    .flag_q(src_flag), .en_q(src_en), .pol_q(src_pol), .pend(pend)
  );

  irqc_line_arb #(
    .NUM_LINES(NUM_LINES), .SRCS_PER_LINE(SRCS_PER_LINE)
  ) u_arb (
    .clk(clk), .rst_n(rst_n), .pend(pend),
    .line_post(line_post), .line_vec(line_vec)
  );

  irqc_core_stage #(
    .NUM_LINES(NUM_LINES), .SRCS_PER_LINE(SRCS_PER_LINE)
  ) u_core (
    .clk(clk), .rst_n(rst_n), .line_post(line_post), .line_vec(line_vec),
    .mask_wr(core_mask_wr), .mask_wdata(core_mask_wdata),
    .flag_clr(core_flag_clr), .gie_set(gie_set), .gie_clr(gie_clr),
    .ack(irq_ack), .flag_q(core_flag), .mask_q(core_mask), .gie_q(gie),
    .irq(irq), .irq_line(irq_line), .irq_pvec(irq_pvec)
  );
endmodule

// File: tb/irqc_top_test.sv
module irqc_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int NL  = 3;
  localparam int SPL = 3;
  localparam int NS  = NL * SPL;
  localparam logic [NS-1:0] PIN_BITS = 9'b001_001_001;

  logic clk = 1'b0;
  logic rst_n;
  logic [NS-1:0] src_in, src_en_wdata, src_pol_wdata, src_flag_clr;
  logic src_en_wr, src_pol_wr, core_mask_wr, gie_set, gie_clr, irq_ack;
  logic [NL-1:0] core_mask_wdata, core_flag_clr;
  logic [NS-1:0] src_flag, src_en, src_pol;
  logic [NL-1:0] core_flag, core_mask;
  logic gie, irq;
  logic [1:0] irq_line, irq_pvec;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irqc_top #(.NUM_LINES(NL), .SRCS_PER_LINE(SPL), .EXT_PER_LINE(1)) uut (
    .clk(clk), .rst_n(rst_n), .src_in(src_in),
    .src_en_wr(src_en_wr), .src_en_wdata(src_en_wdata),
    .src_pol_wr(src_pol_wr), .src_pol_wdata(src_pol_wdata),
    .src_flag_clr(src_flag_clr), .core_mask_wr(core_mask_wr),
    .core_mask_wdata(core_mask_wdata), .core_flag_clr(core_flag_clr),
    .gie_set(gie_set), .gie_clr(gie_clr), .irq_ack(irq_ack),
    .src_flag(src_flag), .src_en(src_en), .src_pol(src_pol),
    .core_flag(core_flag), .core_mask(core_mask), .gie(gie), .irq(irq),
    .irq_line(irq_line), .irq_pvec(irq_pvec)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic clean();
    src_in = '0;
    src_flag_clr = '1;
    core_flag_clr = '1;
    step();
    src_flag_clr = '0;
    core_flag_clr = '0;
    gie_set = 1'b1;
    step();
    gie_set = 1'b0;
  endtask

  task automatic write_en(input logic [NS-1:0] v);
    src_en_wr = 1'b1; src_en_wdata = v;
    step();
    src_en_wr = 1'b0;
  endtask

  function automatic int lowest(input int m);
    for (int k = 0; k < SPL; k++) if (m[k]) return k;
    return 0;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    src_in = '0; src_en_wdata = '0; src_pol_wdata = '0; src_flag_clr = '0;
    src_en_wr = 0; src_pol_wr = 0; core_mask_wr = 0; gie_set = 0; gie_clr = 0;
    irq_ack = 0; core_mask_wdata = '0; core_flag_clr = '0;
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R9: reset state
    chk("R9 flags", int'(src_flag), 0);
    chk("R9 enables", int'(src_en), 0);
    chk("R9 pol", int'(src_pol), 0);
    chk("R9 core_flag", int'(core_flag), 0);
    chk("R9 core_mask", int'(core_mask), 0);
    chk("R9 gie", int'(gie), 0);
    chk("R9 irq", int'(irq), 0);

    // R2: polarity bits of internal sources are not kept
    src_pol_wr = 1'b1; src_pol_wdata = '1;
    step();
    src_pol_wr = 1'b0;
    chk("R2 pol readback", int'(src_pol), int'(PIN_BITS));
    core_mask_wr = 1'b1; core_mask_wdata = '1;
    step();
    core_mask_wr = 1'b0;

    // R1/R3/R4/R5: every source, enable off then on
    for (int en = 0; en < 2; en++) begin
      for (int s = 0; s < NS; s++) begin
        clean();
        write_en(en ? NS'(1 << s) : '0);
        src_in[s] = 1'b1;
        step();
        if (!PIN_BITS[s]) src_in[s] = 1'b0;
        chk($sformatf("R1 flag src%0d en%0d", s, en), int'(src_flag), 1 << s);
        step();
        if (en == 0) begin
          chk($sformatf("R3 disabled src%0d irq", s), int'(irq), 0);
          chk($sformatf("R3 disabled src%0d core", s), int'(core_flag), 0);
          write_en(NS'(1 << s));
          step();
        end
        chk($sformatf("R3 irq src%0d", s), int'(irq), 1);
        chk($sformatf("R5 line src%0d", s), int'(irq_line), s / SPL);
        chk($sformatf("R4 pvec src%0d", s), int'(irq_pvec), s % SPL);
        src_in[s] = 1'b0;
        step();
        chk($sformatf("R2 no falling evt src%0d", s), int'(src_flag), 1 << s);
      end
    end

    // R4: every subset of line 1 arriving together
    for (int m = 1; m < 8; m++) begin
      clean();
      write_en('1);
      src_in[5:3] = 3'(m);
      step();
      src_in[5:4] = 2'b00;
      step();
      chk($sformatf("R4 subset %0d pvec", m), int'(irq_pvec), lowest(m));
      chk($sformatf("R4 subset %0d line", m), int'(irq_line), 1);
      chk($sformatf("R4 subset %0d flags", m), int'(src_flag[5:3]), m);
    end

    // R2: falling polarity on pin source 0
    clean();
    src_pol_wr = 1'b1; src_pol_wdata = PIN_BITS & ~NS'(1);
    step();
    src_pol_wr = 1'b0;
    src_in[0] = 1'b1;
    step();
    chk("R2 rising ignored at pol0", int'(src_flag[0]), 0);
    src_in[0] = 1'b0;
    step();
    chk("R2 falling counts at pol0", int'(src_flag[0]), 1);
    src_pol_wr = 1'b1; src_pol_wdata = PIN_BITS;
    step();
    src_pol_wr = 1'b0;

    // R5: core mask and global enable gating
    clean();
    write_en('1);
    core_mask_wr = 1'b1; core_mask_wdata = '0;
    step();
    core_mask_wr = 1'b0;
    src_in[2] = 1'b1;
    step();
    src_in[2] = 1'b0;
    step();
    chk("R5 masked irq", int'(irq), 0);
    chk("R3 masked core flag", int'(core_flag), 1);
    core_mask_wr = 1'b1; core_mask_wdata = '1;
    step();
    core_mask_wr = 1'b0;
    chk("R5 unmasked irq", int'(irq), 1);
    gie_clr = 1'b1;
    step();
    gie_clr = 1'b0;
    chk("R5 gie off irq", int'(irq), 0);

    // R5/R7: line priority and acknowledge
    clean();
    write_en('1);
    src_in[8] = 1'b1; src_in[5] = 1'b1;
    step();
    src_in[8] = 1'b0; src_in[5] = 1'b0;
    step();
    chk("R5 lowest line", int'(irq_line), 1);
    chk("R4 pvec line1", int'(irq_pvec), 2);
    irq_ack = 1'b1;
    step();
    irq_ack = 1'b0;
    chk("R7 core flags after ack", int'(core_flag), 3'b100);
    chk("R7 gie after ack", int'(gie), 0);
    chk("R7 irq after ack", int'(irq), 0);
    step();
    chk("R7 gie stays off", int'(gie), 0);
    gie_set = 1'b1;
    step();
    gie_set = 1'b0;
    chk("R7 irq after gie_set", int'(irq), 1);
    chk("R7 next line", int'(irq_line), 2);

    // R6: write-one-to-clear
    clean();
    src_in[1] = 1'b1; src_in[2] = 1'b1;
    step();
    src_in = '0;
    src_flag_clr = NS'(2);
    step();
    src_flag_clr = '0;
    chk("R6 w1c one bit", int'(src_flag), 4);
    step();
    chk("R6 zero clear no effect", int'(src_flag), 4);
    core_flag_clr = 3'b001;
    step();
    core_flag_clr = '0;
    chk("R6 core w1c", int'(core_flag & 3'b001), 0);

    // R8: event and clear in the same cycle
    src_in[2] = 1'b1; src_flag_clr = NS'(4);
    step();
    src_in[2] = 1'b0; src_flag_clr = '0;
    chk("R8 event beats clear", int'(src_flag[2]), 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule